// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a system bus. It holds one up-counter that advances by one on each pulse of a slow timer tick, and it compares that counter against two programmable limits. When the counter reaches the first limit, the block raises a level interrupt ("bark"). This gives software a chance to react before the second limit. When the counter reaches the second limit, the block drives a reset request ("bite") to the system reset controller. The two limits are independent, and either one may be the lower.

Software controls the block through a single-cycle register bus. It has four registers: a run enable, a restart ("pet") strobe that zeroes the counter, the bark limit and the bite limit. The usual reprogramming sequence is to disable the counter, pet it, write both limits and enable it again. To force a reset almost at once, software pets the counter and writes a bite limit of 1 while the block is enabled.

Top module: `wdog_two_stage`

## Requirements
- R1: Out of reset, `bark_irq` and `bite_req` are 0, the enable register reads 0, and both limit registers read 0x0FFFFFFF.
- R2: Register byte offsets are: restart 0x04, enable 0x08, bark limit 0x10, bite limit 0x14. The enable register holds only bit 0 and reads back with all other bits zero. Each limit register keeps bits 27:0 of the written data and reads back with bits 31:28 zero.
- R3: A read of the restart offset, or of any offset not listed in R2, returns zero. `rdata` is combinational during a read.
- R4: While enabled, the counter adds one for each cycle in which `tick` is high. When the count reaches the bark limit, `bark_irq` is high from the following clock edge.
- R5: `bark_irq` stays high until a restart write clears it at that write's clock edge, or until the enable bit is cleared, which drops it one cycle after the write.
- R6: A write to the restart offset with data bit 0 set clears the counter. It leaves the enable bit and both limits unchanged. A restart write with bit 0 clear has no effect.
- R7: When the count reaches the bite limit while enabled, `bite_req` rises on the following edge. A bite limit below the bark limit produces a bite with no bark.
- R8: Once `bite_req` is high, it stays high until the block's reset. Restart and enable writes do not clear it.
- R9: The counter saturates at its all-ones value instead of wrapping. A limit equal to all ones never fires.
- R10: If software pets the counter and then writes a bite limit of 1 while enabled, `bite_req` rises one cycle after the next tick.
- R11: While the block is disabled, ticks are ignored and the counter keeps its value, so re-enabling resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when no read is in progress |
| bark_irq | output | 1 | Level interrupt at the bark limit |
| bite_req | output | 1 | Sticky system reset request |

## Verification
The bench disables the block while a bark is pending and sends ticks, then re-enables it. A design that kept counting while disabled would bite at that point. A design that cleared the counter on disable would lose the bark. A second, narrow instance runs its counter past its all-ones value and then lowers the bark limit below the count. A counter that wraps instead of saturating would then hold a small count and fail to bark. The bench also pets the counter with bit 0 clear, sets a bite limit below the bark limit, and clears bark with a bite already pending. These catch a restart that ignores the data bit, comparators that depend on each other, and a bite that clears along with bark.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Byte offsets of the register slots
    localparam int OFS_RESTART = 'h04;
    localparam int OFS_ENABLE  = 'h08;
    localparam int OFS_BARK    = 'h10;
    localparam int OFS_BITE    = 'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RESTART,
        SEL_ENABLE,
        SEL_BARK,
        SEL_BITE
    } wd_sel_e;

    // Control decoded from one bus cycle
    typedef struct packed {
        logic restart;
        logic en_wr;
        logic bark_wr;
        logic bite_wr;
    } wd_ctrl_t;

    function automatic wd_sel_e wd_decode(input logic [31:0] a);
        case (a)
            OFS_RESTART: return SEL_RESTART;
            OFS_ENABLE:  return SEL_ENABLE;
            OFS_BARK:    return SEL_BARK;
            OFS_BITE:    return SEL_BITE;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 28,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic              restart,
    output logic [CNT_W-1:0]  bark_lim,
    output logic [CNT_W-1:0]  bite_lim,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] LIM_NEVER = {CNT_W{1'b1}};

    wd_sel_e  sel;
    wd_ctrl_t ctl;
    logic     unused_hi;

    assign sel       = wd_decode(32'(addr));
    assign unused_hi = ^wdata;

    always_comb begin
        ctl         = '0;
        ctl.restart = wr_en && (sel == SEL_RESTART) && wdata[0];
        ctl.en_wr   = wr_en && (sel == SEL_ENABLE);
        ctl.bark_wr = wr_en && (sel == SEL_BARK);
        ctl.bite_wr = wr_en && (sel == SEL_BITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            bark_lim <= LIM_NEVER;
            bite_lim <= LIM_NEVER;
        end else begin
            if (ctl.en_wr)   en       <= wdata[0];
            if (ctl.bark_wr) bark_lim <= wdata[CNT_W-1:0];
            if (ctl.bite_wr) bite_lim <= wdata[CNT_W-1:0];
        end
    end

    assign restart = ctl.restart;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_ENABLE: rdata = DATA_W'(en);
                SEL_BARK:   rdata = DATA_W'(bark_lim);
                SEL_BITE:   rdata = DATA_W'(bite_lim);
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (en && tick && (cnt != CNT_TOP))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wdog_cmp.sv
module wdog_cmp #(
    parameter int CNT_W  = 28,
    parameter bit STICKY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim,
    output logic             flag
);
    localparam logic [CNT_W-1:0] LIM_NEVER = {CNT_W{1'b1}};

    logic hit;
    assign hit = en && (lim != LIM_NEVER) && (cnt >= lim);

    generate
        if (STICKY) begin : g_sticky
            logic unused_clr;
            assign unused_clr = clr;
            always_ff @(posedge clk) begin
                if (rst) flag <= 1'b0;
                else     flag <= flag | hit;
            end
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst || clr) flag <= 1'b0;
                else            flag <= flag | hit;
            end
        end
    endgenerate

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
    parameter int CNT_W  = 28,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              bark_irq,
    output logic              bite_req
);
    logic             en;
    logic             restart;
    logic [CNT_W-1:0] bark_lim;
    logic [CNT_W-1:0] bite_lim;
    logic [CNT_W-1:0] cnt;

    wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .en(en), .restart(restart), .bark_lim(bark_lim),
        .bite_lim(bite_lim), .rdata(rdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .en(en), .restart(restart), .cnt(cnt)
    );

    wdog_cmp #(.CNT_W(CNT_W), .STICKY(1'b0)) u_bark (
        .clk(clk), .rst(rst), .en(en), .clr(restart || !en),
        .cnt(cnt), .lim(bark_lim), .flag(bark_irq)
    );

    wdog_cmp #(.CNT_W(CNT_W), .STICKY(1'b1)) u_bite (
        .clk(clk), .rst(rst), .en(en), .clr(restart),
        .cnt(cnt), .lim(bite_lim), .flag(bite_req)
    );

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              bark_irq,
    input logic              bite_req
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            p_reset_quiet_r1: assert (!bark_irq && !bite_req)
                else $error("outputs active right after reset");
        end
    end

    p_restart_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && 32'(addr) == OFS_RESTART) |-> (rdata == '0));

    p_pet_drops_bark_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && 32'(addr) == OFS_RESTART && wdata[0]) |=> !bark_irq);

    p_disable_drops_bark_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && 32'(addr) == OFS_ENABLE && !wdata[0]) |=> ##1 !bark_irq);

    p_bite_holds_r8: assert property (@(posedge clk) disable iff (rst)
        bite_req |=> bite_req);

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_CK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [31:0] d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    // OP_CK data encodes {bite_req, bark_irq}
    localparam vec_t VECS [NV] = '{
        '{OP_RD, 8'h08, 32'h0,          8'd1},  // R1 enable 0
        '{OP_RD, 8'h10, 32'h0FFFFFFF,   8'd1},  // R1 bark limit
        '{OP_RD, 8'h14, 32'h0FFFFFFF,   8'd1},  // R1 bite limit
        '{OP_CK, 8'h00, 32'h0,          8'd1},  // R1 outputs
        '{OP_WR, 8'h10, 32'hF0000005,   8'd2},
        '{OP_RD, 8'h10, 32'h00000005,   8'd2},  // R2 upper bits dropped
        '{OP_WR, 8'h14, 32'h00000008,   8'd2},
        '{OP_RD, 8'h14, 32'h00000008,   8'd2},  // R2
        '{OP_WR, 8'h08, 32'hFFFFFFFF,   8'd2},
        '{OP_RD, 8'h08, 32'h00000001,   8'd2},  // R2 enable bit only
        '{OP_RD, 8'h04, 32'h0,          8'd3},  // R3 restart reads 0
        '{OP_RD, 8'h0C, 32'h0,          8'd3},  // R3 unmapped
        '{OP_WR, 8'h04, 32'h1,          8'd6},
        '{OP_TK, 8'h00, 32'd4,          8'd4},
        '{OP_CK, 8'h00, 32'h0,          8'd4},  // R4 below bark
        '{OP_TK, 8'h00, 32'd1,          8'd4},
        '{OP_CK, 8'h00, 32'h1,          8'd4},  // R4 bark at 5
        '{OP_WR, 8'h08, 32'h0,          8'd5},
        '{OP_CK, 8'h00, 32'h0,          8'd5},  // R5 disable drops bark
        '{OP_TK, 8'h00, 32'd10,         8'd11},
        '{OP_CK, 8'h00, 32'h0,          8'd11}, // R11 no count when off
        '{OP_WR, 8'h08, 32'h1,          8'd11},
        '{OP_CK, 8'h00, 32'h1,          8'd11}, // R11 held count 5
        '{OP_WR, 8'h04, 32'h0,          8'd6},
        '{OP_CK, 8'h00, 32'h1,          8'd6},  // R6 bit0 clear no pet
        '{OP_WR, 8'h04, 32'h1,          8'd5},
        '{OP_CK, 8'h00, 32'h0,          8'd5},  // R5 pet drops bark
        '{OP_RD, 8'h10, 32'h5,          8'd6},  // R6 limit kept
        '{OP_RD, 8'h08, 32'h1,          8'd6},  // R6 enable kept
        '{OP_TK, 8'h00, 32'd8,          8'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_n;
    logic        bark_irq, bite_req, bark_n, bite_n;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    wdog_two_stage i_wdog_two_stage (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .bark_irq(bark_irq), .bite_req(bite_req)
    );

    wdog_two_stage #(.CNT_W(6)) i_wdog_two_stage_narrow (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_n),
        .bark_irq(bark_n), .bite_req(bite_n)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 check(rdata, e, req);
        rd_en = 1'b0;
    endtask

    task automatic do_tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_ck(input logic [1:0] e, input int req);
        @(negedge clk);
        check({30'd0, bite_req, bark_irq}, {30'd0, e}, req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R0 actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                OP_WR: do_wr(VECS[v].a, VECS[v].d);
                OP_RD: do_rd(VECS[v].a, VECS[v].d, int'(VECS[v].req));
                OP_TK: do_tk(int'(VECS[v].d));
                default: do_ck(VECS[v].d[1:0], int'(VECS[v].req));
            endcase
        end
        // R7: count 8 hits the bite limit with bark still high
        do_ck(2'b11, 7);
        // R8: pet and disable leave the bite standing
        do_wr(8'h04, 32'h1);
        do_wr(8'h08, 32'h0);
        do_ck(2'b10, 8);

        // R1: reset clears the sticky bite
        do_reset();
        do_ck(2'b00, 1);

        // R7: bite limit below bark limit gives a bite without a bark
        do_wr(8'h10, 32'd10);
        do_wr(8'h14, 32'd3);
        do_wr(8'h08, 32'h1);
        do_tk(3);
        do_ck(2'b10, 7);

        // R9 and R10 on the wide counter
        do_reset();
        do_wr(8'h08, 32'h1);
        do_tk(20);
        do_ck(2'b00, 9);
        do_wr(8'h04, 32'h1);
        do_wr(8'h14, 32'h1);
        do_ck(2'b00, 10);
        do_tk(1);
        do_ck(2'b10, 10);

        // R9: narrow counter saturates at 63 instead of wrapping
        do_reset();
        do_wr(8'h10, 32'h3F);
        do_wr(8'h14, 32'h3F);
        do_wr(8'h08, 32'h1);
        do_tk(80);
        @(negedge clk);
        check({30'd0, bite_n, bark_n}, 32'd0, 9);
        do_wr(8'h10, 32'd20);
        @(negedge clk);
        check({30'd0, bite_n, bark_n}, 32'd1, 9);

        summary();
    end

endmodule